// File: doc/BRIEF.md
# Instruction-Field Register Transfer Unit

This block holds the working registers of an 8-bit accumulator datapath: the accumulator A, six general registers B, C, D, E, H and L, and a scratch register T that only the control sequencer uses. All of them share one 8-bit internal bus. Two 3-bit fields of the current instruction pick the registers. The low field names the register that drives the bus. The next field names the register that captures it. Each field goes through a 3-to-8 decoder that a control-word bit gates, so a single control word moves any register into any other.

Register code 110 names the memory byte whose address is the H:L pair. As a source, that code places the memory read data on the bus. As a destination, it raises a memory write request and no register is loaded. When the source decoder is disabled, the bus carries an external value that the surrounding datapath supplies, such as an ALU result or a memory buffer byte. Loads take effect only at a clock edge on which the write-phase strobe is high. The register pair H:L is always presented as a 16-bit address, and A and T are exported for the ALU.

Top module: `regxfer_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every register (A, B, C, D, E, H, L, T) reads zero until it is first loaded.
- R2: With `src_en` high, `ir_fields[2:0]` selects the bus driver with the codes B=000, C=001, D=010, E=011, H=100, L=101, A=111, and `bus_out` shows that register's value in the same cycle.
- R3: With `src_en` high and source code 110, `bus_out` equals `mem_rdata`.
- R4: With `src_en` low, `bus_out` equals `ext_bus`, whatever the source field holds.
- R5: At a clock edge with `wr_strobe` and `dst_en` both high, the register named by `ir_fields[5:3]` (same codes as R2) takes the bus value. All other registers keep their values.
- R6: A clock edge with `wr_strobe` low, or with `dst_en` low, changes none of A–L.
- R7: `mem_wr_req` is high exactly when `wr_strobe` and `dst_en` are high and the destination code is 110. Such an edge changes no register of A–L.
- R8: At a clock edge with `wr_strobe` and `tmp_load` high, T takes the bus value. Otherwise T holds its value.
- R9: Source and destination act in the same cycle. Fields 111/001 (instruction 01 111 001) copy C into A in one edge. A register that is both source and destination keeps its value.
- R10: `hl_addr` equals {H, L}, with H in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| ir_fields | input | 6 | Instruction bits 5:0: [5:3] destination code, [2:0] source code |
| src_en | input | 1 | Enables the source-field decoder |
| dst_en | input | 1 | Enables the destination-field decoder |
| tmp_load | input | 1 | Loads T from the bus on the write phase |
| wr_strobe | input | 1 | Write-phase strobe; no register loads without it |
| ext_bus | input | 8 | Bus value used when the source decoder is disabled |
| mem_rdata | input | 8 | Memory read data, used for source code 110 |
| bus_out | output | 8 | Internal bus value |
| acc_out | output | 8 | Accumulator A |
| tmp_out | output | 8 | Scratch register T |
| hl_addr | output | 16 | H:L pair as an address |
| mem_wr_req | output | 1 | Memory write request for destination code 110 |

## Verification
The bus read chosen by the source field and the capture chosen by the destination field can fall in the same cycle. This is the single-cycle move. The bench provokes it with fields 111/001, which copy C into A, and with a self-move on D. The captured value must equal the value driven before the edge, and a self-move must leave the register unchanged. A T load in the same cycle as a memory write request is also applied, and the bench checks that T changes while A–L hold.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
  localparam int DATA_W = 8;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    RC_B   = 3'b000,
    RC_C   = 3'b001,
    RC_D   = 3'b010,
    RC_E   = 3'b011,
    RC_H   = 3'b100,
    RC_L   = 3'b101,
    RC_MEM = 3'b110,
    RC_A   = 3'b111
  } reg_code_e;
endpackage

// File: rtl/regxfer_rst_sync.sv
module regxfer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/regxfer_decoder.sv
module regxfer_decoder #(
  parameter int CW = 3,
  localparam int NOUT = 1 << CW
) (
  input  logic          en,
  input  logic [CW-1:0] code,
  output logic [NOUT-1:0] sel
);
  for (genvar g = 0; g < NOUT; g++) begin : g_line
    assign sel[g] = en && (code == CW'(g));
  end
endmodule

// File: rtl/regxfer_regbank.sv
module regxfer_regbank #(
  parameter int DW = 8,
  parameter int CW = 3,
  parameter int MEM_SLOT = 6,
  localparam int NSLOT = 1 << CW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_strobe,
  input  logic [NSLOT-1:0]          dst_sel,
  input  logic [DW-1:0]             bus_in,
  output logic [NSLOT-1:0][DW-1:0]  regs,
  output logic                      mem_wr
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == MEM_SLOT) begin : g_mem
      assign regs[g] = '0;
    end else begin : g_reg
      logic [DW-1:0] val_q;
      logic [DW-1:0] val_d;
      logic          ce;

      assign ce = wr_strobe && dst_sel[g];

      always_comb begin
        val_d = val_q;
        if (ce) val_d = bus_in;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end

      assign regs[g] = val_q;
    end
  end

  assign mem_wr = wr_strobe && dst_sel[MEM_SLOT];
endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
  import regxfer_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*CW-1:0] ir_fields,
  input  logic            src_en,
  input  logic            dst_en,
  input  logic            tmp_load,
  input  logic            wr_strobe,
  input  logic [DW-1:0]   ext_bus,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   bus_out,
  output logic [DW-1:0]   acc_out,
  output logic [DW-1:0]   tmp_out,
  output logic [2*DW-1:0] hl_addr,
  output logic            mem_wr_req
);
  localparam int NSLOT    = 1 << CW;
  localparam int MEM_SLOT = int'(RC_MEM);
  localparam int H_SLOT   = int'(RC_H);
  localparam int L_SLOT   = int'(RC_L);
  localparam int A_SLOT   = int'(RC_A);

  logic                     rst_q_n;
  logic [NSLOT-1:0]         src_sel;
  logic [NSLOT-1:0]         dst_sel;
  logic [NSLOT-1:0][DW-1:0] regs;
  logic [DW-1:0]            bus_c;
  logic [DW-1:0]            tmp_q;
  logic [DW-1:0]            tmp_d;

  regxfer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  regxfer_decoder #(.CW(CW)) u_src_dec (
    .en(src_en), .code(ir_fields[CW-1:0]), .sel(src_sel)
  );

  regxfer_decoder #(.CW(CW)) u_dst_dec (
    .en(dst_en), .code(ir_fields[2*CW-1:CW]), .sel(dst_sel)
  );

  regxfer_regbank #(.DW(DW), .CW(CW), .MEM_SLOT(MEM_SLOT)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_strobe(wr_strobe), .dst_sel(dst_sel),
    .bus_in(bus_c), .regs(regs), .mem_wr(mem_wr_req)
  );

  // Bus: AND-OR of the one-hot source lines; external value when disabled
  always_comb begin
    logic [DW-1:0] sel_val;
    sel_val = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (src_sel[i]) sel_val = sel_val | ((i == MEM_SLOT) ? mem_rdata : regs[i]);
    end
    bus_c = src_en ? sel_val : ext_bus;
  end

  always_comb begin
    tmp_d = tmp_q;
    if (wr_strobe && tmp_load) tmp_d = bus_c;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) tmp_q <= '0;
    else          tmp_q <= tmp_d;
  end

  assign bus_out = bus_c;
  assign acc_out = regs[A_SLOT];
  assign tmp_out = tmp_q;
  assign hl_addr = {regs[H_SLOT], regs[L_SLOT]};
endmodule

// File: rtl/regxfer_chk.sv
module regxfer_chk #(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*CW-1:0] ir_fields,
  input logic            src_en,
  input logic            dst_en,
  input logic            tmp_load,
  input logic            wr_strobe,
  input logic [DW-1:0]   ext_bus,
  input logic [DW-1:0]   mem_rdata,
  input logic [DW-1:0]   bus_out,
  input logic [DW-1:0]   acc_out,
  input logic [DW-1:0]   tmp_out,
  input logic [2*DW-1:0] hl_addr,
  input logic            mem_wr_req
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (acc_out == '0 && tmp_out == '0 && hl_addr == '0)
        else $error("R1 registers not clear in reset");
    end
  end

  p_mem_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && ir_fields[CW-1:0] == 3'b110) |-> bus_out == mem_rdata);

  p_ext_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |-> bus_out == ext_bus);

  p_acc_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && dst_en && ir_fields[2*CW-1:CW] == 3'b111) |=> acc_out == $past(bus_out));

  p_no_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && dst_en) |=> ($stable(acc_out) && $stable(hl_addr)));

  p_memwr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> (wr_strobe && dst_en && ir_fields[2*CW-1:CW] == 3'b110));

  p_memwr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |=> ($stable(acc_out) && $stable(hl_addr)));

  p_tmp_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && tmp_load) |=> tmp_out == $past(bus_out));

  p_tmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe && tmp_load) |=> $stable(tmp_out));
endmodule

bind regxfer_unit regxfer_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .ir_fields(ir_fields), .src_en(src_en),
  .dst_en(dst_en), .tmp_load(tmp_load), .wr_strobe(wr_strobe),
  .ext_bus(ext_bus), .mem_rdata(mem_rdata), .bus_out(bus_out),
  .acc_out(acc_out), .tmp_out(tmp_out), .hl_addr(hl_addr),
  .mem_wr_req(mem_wr_req)
);

// File: tb/regxfer_unit_bench.sv
module regxfer_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  ir_fields;
  logic        src_en, dst_en, tmp_load, wr_strobe;
  logic [7:0]  ext_bus, mem_rdata;
  logic [7:0]  bus_out, acc_out, tmp_out;
  logic [15:0] hl_addr;
  logic        mem_wr_req;

  always #5 clk = ~clk;

  regxfer_unit u_regxfer_unit (
    .clk(clk), .rst_n(rst_n), .ir_fields(ir_fields), .src_en(src_en),
    .dst_en(dst_en), .tmp_load(tmp_load), .wr_strobe(wr_strobe),
    .ext_bus(ext_bus), .mem_rdata(mem_rdata), .bus_out(bus_out),
    .acc_out(acc_out), .tmp_out(tmp_out), .hl_addr(hl_addr),
    .mem_wr_req(mem_wr_req)
  );

  typedef struct {
    string       req;
    logic [7:0]  bus;
    logic        memwr;
    logic [7:0]  acc;
    logic [7:0]  tmp;
    logic [15:0] hl;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] mdl[8];
  logic [7:0] mdl_t;
  int         n_vec  = 0;
  int         n_fail = 0;
  bit         done   = 0;

  // Driver: applies one control word at a falling edge, queues what the
  // outputs must show in that cycle, then advances the model past the edge.
  task automatic apply(string req, logic [2:0] dcode, logic [2:0] scode,
                       logic se, logic de, logic tl, logic ws,
                       logic [7:0] ext, logic [7:0] mem);
    exp_t e;
    @(negedge clk);
    ir_fields = {dcode, scode};
    src_en = se; dst_en = de; tmp_load = tl; wr_strobe = ws;
    ext_bus = ext; mem_rdata = mem;
    e.req   = req;
    e.bus   = !se ? ext : (scode == 3'b110 ? mem : mdl[scode]);
    e.memwr = ws && de && (dcode == 3'b110);
    e.acc   = mdl[7];
    e.tmp   = mdl_t;
    e.hl    = {mdl[4], mdl[5]};
    sb_q.push_back(e);
    if (ws && de && dcode != 3'b110) mdl[dcode] = e.bus;
    if (ws && tl) mdl_t = e.bus;
  endtask

  // Monitor: compares queued expectations in the middle of the low phase.
  always @(negedge clk) begin
    #3;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (bus_out !== e.bus || mem_wr_req !== e.memwr || acc_out !== e.acc ||
          tmp_out !== e.tmp || hl_addr !== e.hl) begin
        n_fail++;
        $display("FAIL %s: bus=%h memwr=%b acc=%h tmp=%h hl=%h expected bus=%h memwr=%b acc=%h tmp=%h hl=%h",
                 e.req, bus_out, mem_wr_req, acc_out, tmp_out, hl_addr,
                 e.bus, e.memwr, e.acc, e.tmp, e.hl);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    ir_fields = '0; src_en = 0; dst_en = 0; tmp_load = 0; wr_strobe = 0;
    ext_bus = '0; mem_rdata = '0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    mdl_t = '0;

    // R1: clear during reset
    apply("R1 in reset", 3'd0, 3'd7, 1, 0, 0, 0, 8'h11, 8'h22);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 after release, R2 read of every register code, R3 memory code
    for (int c = 0; c < 8; c++)
      apply(c == 6 ? "R3 mem source" : "R1 R2 cleared read", 3'd0, 3'(c), 1, 0, 0, 0, 8'hEE, 8'h5A);

    // R4 external bus with source field ignored; R5 load each register
    for (int c = 0; c < 8; c++)
      if (c != 6) apply("R4 R5 load from ext", 3'(c), 3'(c), 0, 1, 0, 1, 8'h30 + 8'(c * 17), 8'h99);

    // R2 read back, R10 H:L address carried in every item
    for (int c = 0; c < 8; c++)
      if (c != 6) apply("R2 R10 read back", 3'd0, 3'(c), 1, 0, 0, 0, 8'h00, 8'h00);

    // R9 single-cycle move C into A (01 111 001), then self move on D
    apply("R9 move C to A", 3'b111, 3'b001, 1, 1, 0, 1, 8'hFF, 8'hFF);
    apply("R9 read A", 3'd0, 3'b111, 1, 0, 0, 0, 8'h00, 8'h00);
    apply("R9 self move D", 3'b010, 3'b010, 1, 1, 0, 1, 8'hFF, 8'hFF);
    apply("R9 read D", 3'd0, 3'b010, 1, 0, 0, 0, 8'h00, 8'h00);

    // R6 no load without strobe or without destination enable
    apply("R6 no strobe", 3'b100, 3'd0, 0, 1, 0, 0, 8'hA5, 8'h00);
    apply("R6 dst disabled", 3'b101, 3'd0, 0, 0, 0, 1, 8'hA5, 8'h00);
    apply("R6 read H", 3'd0, 3'b100, 1, 0, 0, 0, 8'h00, 8'h00);
    apply("R6 read L", 3'd0, 3'b101, 1, 0, 0, 0, 8'h00, 8'h00);

    // R7 memory destination raises request, no register changes; also T loads (R8)
    apply("R7 R8 mem write with T load", 3'b110, 3'b000, 1, 1, 1, 1, 8'h00, 8'h00);
    apply("R7 no strobe no request", 3'b110, 3'b000, 0, 1, 0, 0, 8'h77, 8'h00);
    for (int c = 0; c < 8; c++)
      if (c != 6) apply("R7 regs unchanged", 3'd0, 3'(c), 1, 0, 0, 0, 8'h00, 8'h00);

    // R8 T load from memory data, T hold without strobe
    apply("R8 T from mem", 3'd0, 3'b110, 1, 0, 1, 1, 8'h00, 8'hC3);
    apply("R8 T hold", 3'd0, 3'b110, 1, 0, 1, 0, 8'h00, 8'h3C);
    // ALU-style field 10000 010: D on the bus, nothing captured
    apply("R2 ALU operand D", 3'b000, 3'b010, 1, 0, 0, 0, 8'h00, 8'h00);
    // R5 A captures external ALU result
    apply("R5 A from ext", 3'b111, 3'b000, 0, 1, 0, 1, 8'h6E, 8'h00);
    apply("R5 observe A", 3'd0, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00);

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule